// File: doc/BRIEF.md
# Privilege-Aware Interrupt Enable Mask

This block works out, for each of the twelve interrupt source slots, whether an interrupt could be taken at the hart's current privilege level. It looks at the current privilege level, the global interrupt-enable bits for user, supervisor and machine level, and the two delegation vectors (machine-to-lower and supervisor-to-user). It also looks at two configuration flags that say whether supervisor mode and user-level trap handling exist. The pending-interrupt logic ANDs the resulting mask with the pending and per-source enable vectors before it picks a winner. Priority and cause encoding are handled elsewhere.

When a mode is missing, the delegation vectors that would route traps into that mode are treated as zero. When supervisor mode is absent, a hart running in user mode with user-level traps present treats machine delegation as routing straight to the user handler. The mask is registered, so it reflects the inputs seen at the previous rising clock edge.

Top module: `irq_priv_mask`

## Requirements
- R1: While `rst` is high at a rising edge, `irq_mask_o` becomes all zeros at that edge.
- R2: Mask bit 4*k+l belongs to kind k (0 software, 1 timer, 2 external) at level l (0 user, 1 supervisor, 3 machine). Bits 2, 6 and 10 are always 0.
- R3: The machine delegation vector counts as zero unless `has_smode_i` or `has_utrap_i` is 1.
- R4: The supervisor delegation vector counts as zero unless both `has_smode_i` and `has_utrap_i` are 1.
- R5: In user mode (`priv_i`=2'b00) with `has_smode_i`=1, each machine-level and supervisor-level bit is 1 when its effective supervisor delegation bit is 0 or the effective user enable is 1.
- R6: In user mode with `has_smode_i`=0, each machine-level bit is 1 when its effective machine delegation bit is 0 or the effective user enable is 1, and all supervisor-level bits are 0.
- R7: In user mode, all three user-level bits equal the effective user enable.
- R8: In supervisor mode (`priv_i`=2'b01), each machine-level bit is 1 when its effective machine delegation bit is 0 or `sie_i` is 1.
- R9: In supervisor mode, the supervisor-level bits equal `sie_i` and the user-level bits are 0.
- R10: In machine mode (`priv_i`=2'b11, and also the reserved code 2'b10), the machine-level bits equal `mie_i` and all other bits are 0.
- R11: The effective user enable is `uie_i` AND `has_utrap_i`.
- R12: Outside reset, `irq_mask_o` after a rising edge is the function above of the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| uie_i | input | 1 | User global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| mie_i | input | 1 | Machine global interrupt enable |
| mideleg_i | input | 12 | Machine interrupt delegation vector |
| sideleg_i | input | 12 | Supervisor interrupt delegation vector |
| has_smode_i | input | 1 | Supervisor mode is implemented |
| has_utrap_i | input | 1 | User-level trap handling is implemented |
| irq_mask_o | output | 12 | Registered per-source enable mask |

## Verification
The assertions check several things on every cycle. The reserved slots stay zero. Reset clears the mask. Machine mode leaves every lower-level bit clear. Supervisor mode never enables user-level bits. Supervisor-level bits are dropped in user mode when supervisor mode is absent. User-level bits stay off when user traps are absent. How delegation and the enable bits combine, including the gating of each delegation vector by the configuration flags, can only be seen in the bench. There, a behavioural model is compared against the output on every clock, across directed cases and a long random stream.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

    localparam int NUM_KINDS = 3;   // software, timer, external
    localparam int LVL_SLOTS = 4;   // user, supervisor, reserved, machine
    localparam int MASK_W    = NUM_KINDS * LVL_SLOTS;

    localparam int LVL_U = 0;
    localparam int LVL_S = 1;
    localparam int LVL_R = 2;
    localparam int LVL_M = 3;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPV  = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    typedef logic [MASK_W-1:0] irq_vec_t;

    // per-kind enables for the three real levels
    typedef struct packed {
        logic m_en;
        logic s_en;
        logic u_en;
    } kind_en_t;

    // global enables after configuration gating
    typedef struct packed {
        logic uie;
        logic sie;
        logic mie;
    } glob_en_t;

    function automatic int slot_of(input int kind, input int lvl);
        return kind * LVL_SLOTS + lvl;
    endfunction

    function automatic irq_vec_t level_sel(input int lvl);
        irq_vec_t v;
        v = '0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            v[slot_of(k, lvl)] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_deleg_gate.sv
module irq_deleg_gate
    import irq_mask_pkg::*;
(
    input  irq_vec_t mdel_raw_i,
    input  irq_vec_t sdel_raw_i,
    input  logic     has_smode_i,
    input  logic     has_utrap_i,
    input  logic     uie_raw_i,
    input  logic     sie_raw_i,
    input  logic     mie_raw_i,
    output irq_vec_t mdel_o,
    output irq_vec_t sdel_o,
    output glob_en_t gen_o
);

    logic mdel_live;
    logic sdel_live;

    // machine delegation only has somewhere to go if a lower handler exists
    assign mdel_live = has_smode_i | has_utrap_i;
    // user delegation from supervisor needs both modes
    assign sdel_live = has_smode_i & has_utrap_i;

    assign mdel_o = mdel_live ? mdel_raw_i : '0;
    assign sdel_o = sdel_live ? sdel_raw_i : '0;

    always_comb begin
        gen_o.uie = uie_raw_i & has_utrap_i;
        gen_o.sie = sie_raw_i;
        gen_o.mie = mie_raw_i;
    end

endmodule

// File: rtl/irq_level_mask.sv
module irq_level_mask
    import irq_mask_pkg::*;
(
    input  priv_e    priv_i,
    input  glob_en_t gen_i,
    input  irq_vec_t mdel_i,
    input  irq_vec_t sdel_i,
    input  logic     has_smode_i,
    output irq_vec_t mask_o
);

    kind_en_t kind_en [NUM_KINDS];

    logic unused_del;
    assign unused_del = ^{mdel_i & ~level_sel(LVL_M),
                          sdel_i & ~(level_sel(LVL_M) | level_sel(LVL_S))};

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        localparam int SU = k * LVL_SLOTS + LVL_U;
        localparam int SS = k * LVL_SLOTS + LVL_S;
        localparam int SR = k * LVL_SLOTS + LVL_R;
        localparam int SM = k * LVL_SLOTS + LVL_M;

        always_comb begin
            kind_en[k] = '0;
            unique case (priv_i)
                PRIV_USER: begin
                    if (has_smode_i) begin
                        kind_en[k].m_en = ~sdel_i[SM] | gen_i.uie;
                        kind_en[k].s_en = ~sdel_i[SS] | gen_i.uie;
                    end else begin
                        kind_en[k].m_en = ~mdel_i[SM] | gen_i.uie;
                        kind_en[k].s_en = 1'b0;
                    end
                    kind_en[k].u_en = gen_i.uie;
                end
                PRIV_SUPV: begin
                    kind_en[k].m_en = ~mdel_i[SM] | gen_i.sie;
                    kind_en[k].s_en = gen_i.sie;
                end
                default: begin
                    kind_en[k].m_en = gen_i.mie;
                end
            endcase
        end

        assign mask_o[SU] = kind_en[k].u_en;
        assign mask_o[SS] = kind_en[k].s_en;
        assign mask_o[SR] = 1'b0;
        assign mask_o[SM] = kind_en[k].m_en;
    end

endmodule

// File: rtl/irq_priv_mask.sv
module irq_priv_mask
    import irq_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        priv_i,
    input  logic              uie_i,
    input  logic              sie_i,
    input  logic              mie_i,
    input  logic [MASK_W-1:0] mideleg_i,
    input  logic [MASK_W-1:0] sideleg_i,
    input  logic              has_smode_i,
    input  logic              has_utrap_i,
    output logic [MASK_W-1:0] irq_mask_o
);

    irq_vec_t mdel_eff;
    irq_vec_t sdel_eff;
    glob_en_t gen_eff;
    irq_vec_t mask_d;
    irq_vec_t mask_q;

    irq_deleg_gate u_gate (
        .mdel_raw_i  (mideleg_i),
        .sdel_raw_i  (sideleg_i),
        .has_smode_i (has_smode_i),
        .has_utrap_i (has_utrap_i),
        .uie_raw_i   (uie_i),
        .sie_raw_i   (sie_i),
        .mie_raw_i   (mie_i),
        .mdel_o      (mdel_eff),
        .sdel_o      (sdel_eff),
        .gen_o       (gen_eff)
    );

    irq_level_mask u_lvl (
        .priv_i      (priv_e'(priv_i)),
        .gen_i       (gen_eff),
        .mdel_i      (mdel_eff),
        .sdel_i      (sdel_eff),
        .has_smode_i (has_smode_i),
        .mask_o      (mask_d)
    );

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    assign irq_mask_o = mask_q;

    localparam irq_vec_t RSV_BITS  = level_sel(LVL_R);
    localparam irq_vec_t LOW_BITS  = level_sel(LVL_U) | level_sel(LVL_S);
    localparam irq_vec_t USER_BITS = level_sel(LVL_U);
    localparam irq_vec_t SUPV_BITS = level_sel(LVL_S);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (irq_mask_o == '0)); // R1
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst) ((irq_mask_o & RSV_BITS) == '0)); // R2
    AST_MACH_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
        (priv_i[1] == 1'b1) |=> ((irq_mask_o & LOW_BITS) == '0)); // R10
    AST_SUPV_NO_USER: assert property (@(posedge clk) disable iff (rst)
        (priv_i == 2'b01) |=> ((irq_mask_o & USER_BITS) == '0)); // R9
    AST_USER_NO_S: assert property (@(posedge clk) disable iff (rst)
        (priv_i == 2'b00 && !has_smode_i) |=> ((irq_mask_o & SUPV_BITS) == '0)); // R6
    AST_NO_UTRAP_USER_OFF: assert property (@(posedge clk) disable iff (rst)
        (!has_utrap_i) |=> ((irq_mask_o & USER_BITS) == '0)); // R11

endmodule

// File: tb/tb_irq_priv_mask.sv
module tb_irq_priv_mask;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  priv;
    logic        uie, sie, mie;
    logic [11:0] mdel, sdel;
    logic        hs, hu;
    logic [11:0] mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_priv_mask dut (
        .clk(clk), .rst(rst), .priv_i(priv), .uie_i(uie), .sie_i(sie), .mie_i(mie),
        .mideleg_i(mdel), .sideleg_i(sdel), .has_smode_i(hs), .has_utrap_i(hu),
        .irq_mask_o(mask)
    );

    function automatic logic [11:0] model(input logic [1:0] p, input logic ue, input logic se,
                                          input logic me, input logic [11:0] md,
                                          input logic [11:0] sd, input logic s_ok, input logic u_ok);
        logic [11:0] r;
        logic [11:0] emd;
        logic [11:0] esd;
        logic eu;
        r = 12'h000;
        emd = (s_ok || u_ok) ? md : 12'h000;
        esd = (s_ok && u_ok) ? sd : 12'h000;
        eu = ue && u_ok;
        for (int kind = 0; kind < 3; kind++) begin
            int bu, bs, bm;
            bu = kind * 4; bs = kind * 4 + 1; bm = kind * 4 + 3;
            if (p == 2'b00) begin
                r[bu] = eu;
                if (s_ok) begin
                    r[bm] = !esd[bm] || eu;
                    r[bs] = !esd[bs] || eu;
                end else begin
                    r[bm] = !emd[bm] || eu;
                end
            end else if (p == 2'b01) begin
                r[bm] = !emd[bm] || se;
                r[bs] = se;
            end else begin
                r[bm] = me;
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [11:0] exp);
        checks++;
        if (mask !== exp) begin
            errors++;
            $display("FAIL %s: mask=%03h expected=%03h", tag, mask, exp);
        end
    endtask

    task automatic apply(input logic [1:0] p, input logic ue, input logic se, input logic me,
                         input logic [11:0] md, input logic [11:0] sd,
                         input logic s_ok, input logic u_ok);
        priv = p; uie = ue; sie = se; mie = me; mdel = md; sdel = sd; hs = s_ok; hu = u_ok;
    endtask

    task automatic step(input string tag);
        logic [11:0] exp;
        exp = model(priv, uie, sie, mie, mdel, sdel, hs, hu);
        @(negedge clk);
        check(tag, exp);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        apply(2'b11, 1, 1, 1, 12'hFFF, 12'hFFF, 1, 1);
        repeat (3) @(negedge clk);
        check("R1 reset", 12'h000);
        rst = 1'b0;

        // R10: machine mode, and reserved code behaves as machine
        apply(2'b11, 1, 1, 1, 12'h000, 12'h000, 1, 1); step("R10 mach mie=1");
        check("R10 literal", 12'h888);
        apply(2'b11, 0, 1, 0, 12'h000, 12'h000, 1, 1); step("R10 mach mie=0");
        check("R10 literal off", 12'h000);
        apply(2'b10, 1, 1, 1, 12'h000, 12'h000, 1, 1); step("R10 reserved priv");

        // R8 / R9: supervisor mode
        apply(2'b01, 1, 1, 0, 12'h000, 12'h000, 1, 1); step("R9 supv sie=1");
        check("R9 literal", 12'hAAA);
        apply(2'b01, 1, 0, 1, 12'h888, 12'h000, 1, 1); step("R8 supv all delegated sie=0");
        check("R8 literal", 12'h000);
        apply(2'b01, 0, 0, 0, 12'h080, 12'h000, 1, 0); step("R8 supv timer delegated");
        check("R8 literal partial", 12'h808);
        // R3: delegation ignored with neither lower mode present
        apply(2'b01, 0, 0, 0, 12'hFFF, 12'h000, 0, 0); step("R3 mdel gated");
        check("R3 literal", 12'h888);

        // R5 / R7: user mode with supervisor
        apply(2'b00, 1, 0, 0, 12'h000, 12'h000, 1, 1); step("R7 user uie=1");
        check("R7 literal", 12'hBBB);
        apply(2'b00, 0, 0, 0, 12'h000, 12'hAAA, 1, 1); step("R5 all sdel set uie=0");
        check("R5 literal", 12'h000);
        apply(2'b00, 1, 0, 0, 12'h000, 12'hAAA, 1, 1); step("R5 all sdel set uie=1");
        // R4: sdel ignored without user traps; R11: uie ignored too
        apply(2'b00, 1, 0, 0, 12'h000, 12'hAAA, 1, 0); step("R4 sdel gated");
        check("R4 literal", 12'hAAA);
        check("R11 user bits off", 12'hAAA);

        // R6: user mode, no supervisor, machine delegation to user handler
        apply(2'b00, 0, 1, 1, 12'h808, 12'hFFF, 0, 1); step("R6 mdel to user");
        check("R6 literal", 12'h080);
        apply(2'b00, 1, 1, 1, 12'h888, 12'hFFF, 0, 1); step("R6 uie=1");
        check("R6 literal uie", 12'h999);
        apply(2'b00, 1, 1, 1, 12'h888, 12'hFFF, 0, 0); step("R11 no utrap");
        check("R2 R11 literal", 12'h888);

        // R12 / R2: random stream compared every clock
        for (int i = 0; i < 3000; i++) begin
            apply(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  12'($urandom), 12'($urandom), 1'($urandom), 1'($urandom));
            step("R12 random");
            checks++;
            if (mask[2] || mask[6] || mask[10]) begin
                errors++;
                $display("FAIL R2 reserved: mask=%03h expected reserved=0", mask);
            end
        end

        // R1 again mid-run
        apply(2'b11, 1, 1, 1, 12'h000, 12'h000, 1, 1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", 12'h000);
        rst = 1'b0;
        step("R12 after reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule